// File: doc/BRIEF.md
# Bidirectional FIFO Mailbox Pipe

Two processors share one clock and exchange bytes through this block. Each processor sees a small port of four addresses. Each port has a chip select, a two-bit address, read and write strobes, and byte-wide data in both directions. The port reaches a 16-entry byte FIFO that carries data toward the other side, and a second FIFO that carries data back.

Control actions are not stored as register bits. A strobe to a chosen address carries out the action as a side effect. Whether the access is a read or a write also matters. The actions are resetting either FIFO, or both FIFOs, and raising or dropping an interrupt.

There is one interrupt flip-flop per direction. Only the far side can raise the flag pointing at a processor. Only that processor can drop it. A status byte shows the fill state of both FIFOs and the pending flag. Read data is combinational during a read strobe and is 0x00 at all other times.

Top module: `mbox_pipe`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties both FIFOs and clears both interrupt flags. After reset, the status byte on each side reads 0x04.
- R2: A write at address 0 pushes the byte into the send FIFO of that side. A read at address 0 on the other side returns the oldest byte during the strobe cycle and removes it at the clock edge. Order is kept, and up to 16 bytes can be held.
- R3: A write at address 0 while the send FIFO holds 16 bytes is dropped. The FIFO contents and count stay unchanged.
- R4: A read at address 0 while the receive FIFO is empty returns 0x00 and leaves the FIFO unchanged.
- R5: A read at address 1 returns the status byte. Its fields are: bit0 receive not empty, bit1 receive full, bit2 send empty, bit3 send full, bit4 the interrupt flag pointing at this side. Bits 7..5 read as 0.
- R6: While a side has no chip-selected read strobe, its read data output is 0x00.
- R7: A write at address 1 sets the interrupt flag pointing at the other side. The flag drives that side's interrupt output from the next clock edge on, and it holds until it is cleared or reset.
- R8: A write at address 2 clears the interrupt flag pointing at the writing side. If a set and a clear of the same flag land in the same cycle, the clear wins.
- R9: A read at address 2 empties the send FIFO of the reading side. Its receive FIFO is untouched.
- R10: A read at address 3 empties the receive FIFO of the reading side. Its send FIFO is untouched.
- R11: A write at address 3 on either side empties both FIFOs.
- R12: Strobes with the chip select low have no effect on either FIFO or either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| a_cs | input | 1 | Side A chip select |
| a_addr | input | 2 | Side A address |
| a_rd | input | 1 | Side A read strobe |
| a_wr | input | 1 | Side A write strobe |
| a_wdata | input | 8 | Side A write data |
| a_rdata | output | 8 | Side A read data, 0x00 when not reading |
| b_cs | input | 1 | Side B chip select |
| b_addr | input | 2 | Side B address |
| b_rd | input | 1 | Side B read strobe |
| b_wr | input | 1 | Side B write strobe |
| b_wdata | input | 8 | Side B write data |
| b_rdata | output | 8 | Side B read data, 0x00 when not reading |
| irq_a | output | 1 | Interrupt toward side A |
| irq_b | output | 1 | Interrupt toward side B |

## Verification
A wrong pointer or count shows at the ports as soon as the next status read or the next pop. The status read shows it as a wrong empty or full bit. The pop shows it as a byte out of order, a byte missing, or a byte repeated. A scoreboard queue per direction catches these in the same cycle as the strobe.

An interrupt flag with the wrong value is visible on the interrupt output one edge after the access that should have changed it. This includes a set that wins over a clear.

Reset actions aimed at one FIFO are checked through both sides' status bytes. A reset that also hits the untargeted FIFO appears right away as a wrong empty bit.

// File: rtl/mbox_pipe.sv
module mbox_pipe #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_cs,
  input  logic [1:0]    a_addr,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_cs,
  input  logic [1:0]    b_addr,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]    cs, rd, wr;
  logic [1:0]    ad   [2];
  logic [DW-1:0] wd   [2];
  logic [DW-1:0] rdq  [2];
  logic [DW-1:0] head [2];
  logic [3:0]    rsel [2];
  logic [3:0]    wsel [2];
  logic [1:0]    empty, full, flag;

  assign cs = {b_cs, a_cs};
  assign rd = {b_rd, a_rd};
  assign wr = {b_wr, a_wr};
  assign ad[0] = a_addr;
  assign ad[1] = b_addr;
  assign wd[0] = a_wdata;
  assign wd[1] = b_wdata;
  assign a_rdata = rdq[0];
  assign b_rdata = rdq[1];
  assign irq_a = flag[0];
  assign irq_b = flag[1];

  wire clr_all = wsel[0][3] | wsel[1][3];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int O = 1 - s;

    assign rsel[s] = (cs[s] && rd[s]) ? (4'b0001 << ad[s]) : 4'b0000;
    assign wsel[s] = (cs[s] && wr[s]) ? (4'b0001 << ad[s]) : 4'b0000;

    // FIFO s carries data from side s to side O
    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wp, rp;
    wire push = wsel[s][0];
    wire pop  = rsel[O][0];
    wire clr  = rsel[s][2] | rsel[O][3] | clr_all;

    assign empty[s] = (wp == rp);
    assign full[s]  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign head[s]  = empty[s] ? '0 : mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push && !full[s]) wp <= wp + 1'b1;
        if (pop && !empty[s]) rp <= rp + 1'b1;
      end
    end

    always_ff @(posedge clk)
      if (push && !full[s]) mem[wp[AW-1:0]] <= wd[s];

    // flag s points at side s: set by side O, cleared by side s
    always_ff @(posedge clk) begin
      if (rst || wsel[s][2]) flag[s] <= 1'b0;
      else if (wsel[O][1])   flag[s] <= 1'b1;
    end

    wire [DW-1:0] status = {{(DW-5){1'b0}}, flag[s], full[s], empty[s], full[O], !empty[O]};

    assign rdq[s] = rsel[s][0] ? head[O] :
                    rsel[s][1] ? status  : '0;
  end
endmodule

// File: rtl/mbox_pipe_props.sv
module mbox_pipe_props #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          a_cs,
  input logic [1:0]    a_addr,
  input logic          a_rd,
  input logic          a_wr,
  input logic [DW-1:0] a_rdata,
  input logic          b_cs,
  input logic [1:0]    b_addr,
  input logic          b_rd,
  input logic          b_wr,
  input logic [DW-1:0] b_rdata,
  input logic          irq_a,
  input logic          irq_b
);
  wire a_set = a_cs && a_wr && a_addr == 2'd1;
  wire a_clr = a_cs && a_wr && a_addr == 2'd2;
  wire b_set = b_cs && b_wr && b_addr == 2'd1;
  wire b_clr = b_cs && b_wr && b_addr == 2'd2;

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (!irq_a && !irq_b));

  assert_idle_bus_a_R6: assert property (@(posedge clk) disable iff (rst)
    !(a_cs && a_rd) |-> a_rdata == '0);
  assert_idle_bus_b_R6: assert property (@(posedge clk) disable iff (rst)
    !(b_cs && b_rd) |-> b_rdata == '0);

  assert_status_pad_R5: assert property (@(posedge clk) disable iff (rst)
    (a_cs && a_rd && a_addr == 2'd1) |-> a_rdata[DW-1:5] == '0);

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (rst)
    (b_set && !a_clr) |=> irq_a);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!a_set && !b_clr) |=> $stable(irq_b));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    b_clr |=> !irq_b);
  assert_clear_wins_a_R8: assert property (@(posedge clk) disable iff (rst)
    a_clr |=> !irq_a);
endmodule

bind mbox_pipe mbox_pipe_props #(.DW(DW)) u_props (.*);

// File: tb/mbox_pipe_test.sv
module mbox_pipe_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_cs = 0, a_rd = 0, a_wr = 0, b_cs = 0, b_rd = 0, b_wr = 0;
  logic [1:0] a_addr = 0, b_addr = 0;
  logic [7:0] a_wdata = 0, b_wdata = 0;
  logic [7:0] a_rdata, b_rdata;
  logic irq_a, irq_b;

  int checks = 0, errors = 0;
  logic [7:0] q_ab [$];
  logic [7:0] q_ba [$];
  bit mflag [2];
  logic [7:0] rv;

  always #10 clk = ~clk;

  mbox_pipe uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(input bit s);
    int rx = s ? q_ab.size() : q_ba.size();
    int tx = s ? q_ba.size() : q_ab.size();
    return {3'b0, mflag[s], tx == 16, tx == 0, rx == 16, rx != 0};
  endfunction

  task automatic model(input bit s, input bit w, input logic [1:0] ad, input logic [7:0] d);
    if (w) begin
      case (ad)
        2'd0: if (s == 0) begin if (q_ab.size() < 16) q_ab.push_back(d); end
              else begin if (q_ba.size() < 16) q_ba.push_back(d); end
        2'd1: mflag[!s] = 1'b1;
        2'd2: mflag[s] = 1'b0;
        2'd3: begin q_ab.delete(); q_ba.delete(); end
      endcase
    end else begin
      if (ad == 2'd2) begin if (s == 0) q_ab.delete(); else q_ba.delete(); end
      if (ad == 2'd3) begin if (s == 0) q_ba.delete(); else q_ab.delete(); end
    end
  endtask

  task automatic go(input bit s, input bit w, input logic [1:0] ad, input logic [7:0] d,
                    output logic [7:0] q);
    @(posedge clk); #1;
    if (s == 0) begin a_cs = 1; a_rd = !w; a_wr = w; a_addr = ad; a_wdata = d; end
    else        begin b_cs = 1; b_rd = !w; b_wr = w; b_addr = ad; b_wdata = d; end
    model(s, w, ad, d);
    @(negedge clk);
    q = s ? b_rdata : a_rdata;
    @(posedge clk); #1;
    a_cs = 0; a_rd = 0; a_wr = 0; b_cs = 0; b_rd = 0; b_wr = 0;
  endtask

  task automatic stat(input bit s, input string tag);
    logic [7:0] q;
    go(s, 0, 2'd1, 8'h00, q);
    chk(tag, q, exp_stat(s));
  endtask

  // monitor: pops the scoreboard whenever a side reads its receive FIFO
  always @(negedge clk) begin
    if (!rst) begin
      if (b_cs && b_rd && b_addr == 2'd0) begin
        if (q_ab.size() != 0) chk("R2 pop on B", b_rdata, q_ab.pop_front());
        else                  chk("R4 empty pop on B", b_rdata, 8'h00);
      end
      if (a_cs && a_rd && a_addr == 2'd0) begin
        if (q_ba.size() != 0) chk("R2 pop on A", a_rdata, q_ba.pop_front());
        else                  chk("R4 empty pop on A", a_rdata, 8'h00);
      end
    end
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    stat(0, "R1 status A after reset");
    stat(1, "R1 status B after reset");
    chk("R1 irq after reset", {irq_a, irq_b}, 8'h00);

    // R2: ordered transfer both ways
    for (int i = 0; i < 3; i++) go(0, 1, 2'd0, 8'hA0 + 8'(i), rv);
    go(1, 1, 2'd0, 8'h5C, rv);
    stat(1, "R5 status B with rx data");
    stat(0, "R5 status A with rx data");
    for (int i = 0; i < 3; i++) go(1, 0, 2'd0, 8'h00, rv);
    go(0, 0, 2'd0, 8'h00, rv);
    go(0, 0, 2'd0, 8'h00, rv);   // R4 pop on empty

    // R3: fill to 16, 17th dropped
    for (int i = 0; i < 17; i++) go(0, 1, 2'd0, 8'h10 + 8'(i), rv);
    stat(1, "R3 status B when full");
    stat(0, "R3 status A when full");
    for (int i = 0; i < 17; i++) go(1, 0, 2'd0, 8'h00, rv);
    stat(1, "R4 status B after drain");

    // R6 and R12: no chip select
    @(posedge clk); #1; a_wr = 1; a_addr = 2'd0; a_wdata = 8'hEE; b_rd = 1; b_addr = 2'd1;
    @(negedge clk); chk("R6 rdata without cs", b_rdata, 8'h00);
    @(posedge clk); #1; a_wr = 0; b_rd = 0;
    @(posedge clk); #1; a_wr = 1; a_addr = 2'd1; a_rd = 0;
    @(posedge clk); #1; a_wr = 0;
    stat(1, "R12 no push without cs");
    chk("R12 no irq without cs", {7'b0, irq_b}, 8'h00);

    // R7 / R8 interrupts
    go(0, 1, 2'd1, 8'h00, rv);
    chk("R7 irq_b after A set", {7'b0, irq_b}, 8'h01);
    chk("R7 irq_a untouched", {7'b0, irq_a}, 8'h00);
    stat(1, "R5 status B shows flag");
    go(0, 1, 2'd2, 8'h00, rv);
    chk("R8 A cannot clear B flag", {7'b0, irq_b}, 8'h01);
    @(posedge clk); #1;
    a_cs = 1; a_wr = 1; a_addr = 2'd1; b_cs = 1; b_wr = 1; b_addr = 2'd2;
    @(posedge clk); #1;
    a_cs = 0; a_wr = 0; b_cs = 0; b_wr = 0;
    mflag[1] = 1'b0;
    chk("R8 clear wins", {7'b0, irq_b}, 8'h00);
    go(1, 1, 2'd1, 8'h00, rv);
    chk("R7 irq_a after B set", {7'b0, irq_a}, 8'h01);
    go(0, 1, 2'd2, 8'h00, rv);
    chk("R8 irq_a after A clear", {7'b0, irq_a}, 8'h00);

    // R9 / R10 / R11 targeted resets
    go(0, 1, 2'd0, 8'h31, rv); go(0, 1, 2'd0, 8'h32, rv);
    go(1, 1, 2'd0, 8'h41, rv); go(1, 1, 2'd0, 8'h42, rv);
    go(0, 0, 2'd2, 8'h00, rv);
    stat(1, "R9 B rx empty after A send reset");
    stat(0, "R9 A rx kept after A send reset");
    go(0, 1, 2'd0, 8'h33, rv);
    go(0, 0, 2'd3, 8'h00, rv);
    stat(0, "R10 A rx empty after A rx reset");
    stat(1, "R10 B rx kept after A rx reset");
    go(1, 0, 2'd0, 8'h00, rv);
    go(0, 1, 2'd0, 8'h34, rv); go(1, 1, 2'd0, 8'h43, rv);
    go(1, 1, 2'd3, 8'h00, rv);
    stat(0, "R11 A after reset both");
    stat(1, "R11 B after reset both");

    // R1: global reset mid-traffic
    go(0, 1, 2'd0, 8'h55, rv); go(1, 1, 2'd1, 8'h00, rv);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    q_ab.delete(); q_ba.delete(); mflag[0] = 0; mflag[1] = 0;
    chk("R1 irq cleared by reset", {7'b0, irq_a}, 8'h00);
    stat(1, "R1 status B after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule